// File: doc/BRIEF.md
# Masked Display Timing Pulse Generator

This block derives control waveforms for a display panel from a free-running horizontal pixel count and a vertical line count. It has a bank of masked position comparators and a bank of programmable set/clear pulse channels. A comparator raises a strobe whenever its programmed value equals the masked horizontal count, or the masked vertical count. The comparator's own select bit picks which count is used. A pulse channel drives a level output. The output goes high at a programmed set position and low at a programmed clear position.

Each pulse channel has one of four modes. In the horizontal mode, both positions are compared against the pixel count. In the vertical line-start mode, they are compared against the line count, and the output changes in the first cycle of the matching line. In the two gated vertical modes, the line count must match and a chosen comparator must also hit in the same cycle. This places the edge at a chosen pixel within that line.

Any count bit can be made a don't-care. To do this, clear that bit in both the mask and the programmed value. All configuration arrives on flat register-style inputs. The outputs appear one clock after the counts that cause them.

Top module: `disp_pulse_timer`

## Requirements
- R1: With its select bit at 0, comparator i raises `cmp_strobe[i]` in the cycle after `cmp_val` equals `cmp_msk & hcnt`. In every other cycle the strobe is low.
- R2: With its select bit at 1, a comparator uses `vcnt` instead of `hcnt` in the same rule.
- R3: A count bit whose mask bit and value bit are both 0 has no effect on a match, for comparators and for both positions of every pulse channel.
- R4: Mode 2'b00 (horizontal): the output is 1 in the cycle after the set position matches `hcnt`, and 0 in the cycle after the clear position matches `hcnt`.
- R5: In mode 2'b00 the channel's comparator select has no effect on the output.
- R6: Modes 2'b01 and 2'b11 (gated vertical): the set and clear positions are compared with `vcnt`. A match takes effect only in a cycle where the comparator named by the channel's 2-bit select (field `pls_csel[2*j +: 2]`) also matches.
- R7: Mode 2'b10 (line start): the set and clear positions are compared with `vcnt`, and a match takes effect with no horizontal qualification.
- R8: When the set and clear conditions are both true in the same cycle, the output goes to 0.
- R9: While `rst_n` is low, all strobes and pulse outputs are 0. Reset release is synchronized, and outputs stay 0 for two clocks after release.
- R10: A pulse output keeps its value in any cycle where neither its set nor its clear condition is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | CNT_W | Horizontal pixel count |
| vcnt | input | CNT_W | Vertical line count |
| cmp_val | input | N_CMP*CNT_W | Comparator values, comparator i at `[i*CNT_W +: CNT_W]` |
| cmp_msk | input | N_CMP*CNT_W | Comparator masks, same layout |
| cmp_vsel | input | N_CMP | Per comparator: 0 compares hcnt, 1 compares vcnt |
| pls_set | input | N_PLS*CNT_W | Set positions |
| pls_set_msk | input | N_PLS*CNT_W | Set position masks |
| pls_clr | input | N_PLS*CNT_W | Clear positions |
| pls_clr_msk | input | N_PLS*CNT_W | Clear position masks |
| pls_mode | input | 2*N_PLS | Per-channel mode, 2 bits each |
| pls_csel | input | 2*N_PLS | Per-channel comparator select, 2 bits each |
| cmp_strobe | output | N_CMP | Registered comparator match strobes |
| pls_out | output | N_PLS | Pulse channel levels |

## Verification
Random configurations use sparse masks. This makes matches, misses and don't-care bits all common, while counts and every channel's mode and select vary widely. A bench model of the matching rule tells the horizontal mode apart from each vertical mode in every cycle. Because the select changes freely, the same model also shows that the select is ignored in horizontal mode. Directed cases cover two situations. In the first, a mask hides a differing count bit, and a match must still occur. In the second, the set and clear positions are equal, so the clear must win. A gated channel is also held on a matching line while its chosen comparator stays silent, so that leaving the output unchanged can be told apart from following the line match.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

  typedef enum logic [1:0] {
    PM_HORZ   = 2'b00,
    PM_VGATE  = 2'b01,
    PM_VLINE  = 2'b10,
    PM_VGATE2 = 2'b11
  } pmode_e;

endpackage

// File: rtl/pos_cmp.sv
module pos_cmp #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  input  logic [CNT_W-1:0] val,
  input  logic [CNT_W-1:0] msk,
  input  logic             vsel,
  output logic             hit,
  output logic             strobe
);

  logic [CNT_W-1:0] cnt_sel;
  logic             strobe_q;

  always_comb begin
    cnt_sel = vsel ? vcnt : hcnt;
    hit     = (val == (msk & cnt_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= hit;
  end

  assign strobe = strobe_q;

  AST_CMP_H_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsel && (val == (msk & hcnt))) |=> strobe); // R1
  AST_CMP_V_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel && (val == (msk & vcnt))) |=> strobe); // R2
  AST_CMP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (val != (msk & (vsel ? vcnt : hcnt))) |=> !strobe); // R1

endmodule

// File: rtl/pulse_chan.sv
module pulse_chan
  import disp_timing_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int N_CMP = 4,
  localparam int CSW  = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  input  logic [CNT_W-1:0] set_val,
  input  logic [CNT_W-1:0] set_msk,
  input  logic [CNT_W-1:0] clr_val,
  input  logic [CNT_W-1:0] clr_msk,
  input  logic [1:0]       mode,
  input  logic [CSW-1:0]   csel,
  input  logic [N_CMP-1:0] cmp_hit,
  output logic             pls_out
);

  pmode_e           mode_e;
  logic [CNT_W-1:0] cnt_sel;
  logic             gated;
  logic             gate_ok;
  logic             set_go;
  logic             clr_go;
  logic             out_nxt;
  logic             out_q;

  always_comb begin
    mode_e  = pmode_e'(mode);
    cnt_sel = (mode_e == PM_HORZ) ? hcnt : vcnt;
    gated   = (mode_e == PM_VGATE) || (mode_e == PM_VGATE2);
    gate_ok = gated ? cmp_hit[csel] : 1'b1;
    set_go  = (set_val == (set_msk & cnt_sel)) && gate_ok;
    clr_go  = (clr_val == (clr_msk & cnt_sel)) && gate_ok;
    if (clr_go)      out_nxt = 1'b0;
    else if (set_go) out_nxt = 1'b1;
    else             out_nxt = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_nxt;
  end

  assign pls_out = out_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> !pls_out); // R8
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode == 2'b01) || (mode == 2'b11)) && !cmp_hit[csel]) |=> $stable(pls_out)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_go && !clr_go) |=> $stable(pls_out)); // R10
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pls_out) |-> $past(set_go)); // R4

endmodule

// File: rtl/disp_pulse_timer.sv
module disp_pulse_timer #(
  parameter int CNT_W = 11,
  parameter int N_CMP = 4,
  parameter int N_PLS = 6,
  localparam int CSW  = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       hcnt,
  input  logic [CNT_W-1:0]       vcnt,
  input  logic [N_CMP*CNT_W-1:0] cmp_val,
  input  logic [N_CMP*CNT_W-1:0] cmp_msk,
  input  logic [N_CMP-1:0]       cmp_vsel,
  input  logic [N_PLS*CNT_W-1:0] pls_set,
  input  logic [N_PLS*CNT_W-1:0] pls_set_msk,
  input  logic [N_PLS*CNT_W-1:0] pls_clr,
  input  logic [N_PLS*CNT_W-1:0] pls_clr_msk,
  input  logic [2*N_PLS-1:0]     pls_mode,
  input  logic [CSW*N_PLS-1:0]   pls_csel,
  output logic [N_CMP-1:0]       cmp_strobe,
  output logic [N_PLS-1:0]       pls_out
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [N_CMP-1:0] cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    pos_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .hcnt   (hcnt),
      .vcnt   (vcnt),
      .val    (cmp_val[i*CNT_W +: CNT_W]),
      .msk    (cmp_msk[i*CNT_W +: CNT_W]),
      .vsel   (cmp_vsel[i]),
      .hit    (cmp_hit[i]),
      .strobe (cmp_strobe[i])
    );
  end

  for (genvar j = 0; j < N_PLS; j++) begin : g_pls
    pulse_chan #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_pls (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .hcnt    (hcnt),
      .vcnt    (vcnt),
      .set_val (pls_set[j*CNT_W +: CNT_W]),
      .set_msk (pls_set_msk[j*CNT_W +: CNT_W]),
      .clr_val (pls_clr[j*CNT_W +: CNT_W]),
      .clr_msk (pls_clr_msk[j*CNT_W +: CNT_W]),
      .mode    (pls_mode[2*j +: 2]),
      .csel    (pls_csel[CSW*j +: CSW]),
      .cmp_hit (cmp_hit),
      .pls_out (pls_out[j])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (cmp_strobe == '0 && pls_out == '0)); // R9

endmodule

// File: tb/test_disp_pulse_timer.sv
module test_disp_pulse_timer;
  localparam int CW = 11;
  localparam int NC = 4;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] hcnt = '0, vcnt = '0;
  logic [NC*CW-1:0] cmp_val = '0, cmp_msk = '0;
  logic [NC-1:0] cmp_vsel = '0;
  logic [NP*CW-1:0] pls_set = '0, pls_set_msk = '0, pls_clr = '0, pls_clr_msk = '0;
  logic [2*NP-1:0] pls_mode = '0, pls_csel = '0;
  logic [NC-1:0] cmp_strobe;
  logic [NP-1:0] pls_out;

  int tests = 0, fails = 0;
  logic [NP-1:0] exp_p = '0;
  string tag = "";
  bit done = 0;

  always #10 clk = ~clk;

  disp_pulse_timer #(.CNT_W(CW), .N_CMP(NC), .N_PLS(NP)) i_disp_pulse_timer (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .cmp_val(cmp_val), .cmp_msk(cmp_msk), .cmp_vsel(cmp_vsel),
    .pls_set(pls_set), .pls_set_msk(pls_set_msk), .pls_clr(pls_clr),
    .pls_clr_msk(pls_clr_msk), .pls_mode(pls_mode), .pls_csel(pls_csel),
    .cmp_strobe(cmp_strobe), .pls_out(pls_out));

  function automatic logic meq(logic [CW-1:0] v, logic [CW-1:0] m, logic [CW-1:0] c);
    return v == (m & c);
  endfunction

  function automatic logic [CW-1:0] sparse_mask();
    logic [CW-1:0] m = '0;
    for (int k = 0; k < 3; k++) m[$urandom_range(CW-1, 0)] = 1'b1;
    return m;
  endfunction

  task automatic check(logic got, logic exp, string req, int ch);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s ch%0d got %b expected %b", req, tag, ch, got, exp);
    end
  endtask

  task automatic step();
    logic [NC-1:0] hit;
    logic [NP-1:0] nxt;
    for (int i = 0; i < NC; i++)
      hit[i] = meq(cmp_val[i*CW +: CW], cmp_msk[i*CW +: CW], cmp_vsel[i] ? vcnt : hcnt);
    for (int j = 0; j < NP; j++) begin
      logic [1:0] md = pls_mode[2*j +: 2];
      logic [CW-1:0] c = (md == 2'b00) ? hcnt : vcnt;
      logic g = (md == 2'b01 || md == 2'b11) ? hit[pls_csel[2*j +: 2]] : 1'b1;
      logic s = meq(pls_set[j*CW +: CW], pls_set_msk[j*CW +: CW], c) && g;
      logic r = meq(pls_clr[j*CW +: CW], pls_clr_msk[j*CW +: CW], c) && g;
      nxt[j] = r ? 1'b0 : (s ? 1'b1 : exp_p[j]);
    end
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NC; i++)
      check(cmp_strobe[i], hit[i], cmp_vsel[i] ? "R2" : "R1", i);
    for (int j = 0; j < NP; j++) begin
      logic [1:0] md = pls_mode[2*j +: 2];
      if (md == 2'b00)      check(pls_out[j], nxt[j], "R4 R5 R10", j);
      else if (md == 2'b10) check(pls_out[j], nxt[j], "R7 R10", j);
      else                  check(pls_out[j], nxt[j], "R6 R10", j);
    end
    exp_p = nxt;
  endtask

  task automatic rand_config();
    for (int i = 0; i < NC; i++) begin
      logic [CW-1:0] m = sparse_mask();
      cmp_msk[i*CW +: CW] = m;
      cmp_val[i*CW +: CW] = CW'($urandom) & m;
      cmp_vsel[i] = 1'($urandom);
    end
    for (int j = 0; j < NP; j++) begin
      logic [CW-1:0] m1 = sparse_mask();
      logic [CW-1:0] m2 = sparse_mask();
      pls_set_msk[j*CW +: CW] = m1;
      pls_set[j*CW +: CW] = CW'($urandom) & m1;
      pls_clr_msk[j*CW +: CW] = m2;
      pls_clr[j*CW +: CW] = CW'($urandom) & m2;
      pls_mode[2*j +: 2] = 2'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    tag = "reset";
    #35;
    for (int i = 0; i < NC; i++) check(cmp_strobe[i], 1'b0, "R9", i);
    for (int j = 0; j < NP; j++) check(pls_out[j], 1'b0, "R9", j);
    @(negedge clk);
    cmp_msk = '0; cmp_val = '0;
    pls_set_msk = '0; pls_set = '0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    tag = "sync release";
    for (int i = 0; i < NC; i++) check(cmp_strobe[i], 1'b0, "R9", i);
    for (int j = 0; j < NP; j++) check(pls_out[j], 1'b0, "R9", j);
    @(posedge clk); @(negedge clk);
    pls_set = '1; pls_set_msk = '1; pls_clr = '1; pls_clr_msk = '1;
    cmp_val = '1; cmp_msk = '1;

    tag = "masked bit";
    cmp_vsel[0] = 1'b0;
    cmp_msk[0 +: CW] = CW'(3'b101); cmp_val[0 +: CW] = CW'(3'b100);
    pls_mode[1:0] = 2'b00;
    pls_set_msk[0 +: CW] = CW'(3'b101); pls_set[0 +: CW] = CW'(3'b100);
    hcnt = CW'(3'b110); step();
    check(cmp_strobe[0], 1'b1, "R3", 0);
    check(pls_out[0], 1'b1, "R3", 0);
    hcnt = CW'(3'b111); step();
    check(cmp_strobe[0], 1'b0, "R3", 0);

    tag = "set equals clear";
    pls_mode[3:2] = 2'b00;
    pls_set_msk[CW +: CW] = '1; pls_set[CW +: CW] = CW'(40);
    pls_clr_msk[CW +: CW] = '1; pls_clr[CW +: CW] = CW'(20);
    hcnt = CW'(40); step();
    check(pls_out[1], 1'b1, "R4", 1);
    pls_clr[CW +: CW] = CW'(40); step();
    check(pls_out[1], 1'b0, "R8", 1);

    tag = "gate silent";
    pls_mode[5:4] = 2'b01; pls_csel[5:4] = 2'd3;
    cmp_vsel[3] = 1'b0; cmp_msk[3*CW +: CW] = '1; cmp_val[3*CW +: CW] = CW'(500);
    pls_set_msk[2*CW +: CW] = '1; pls_set[2*CW +: CW] = CW'(7);
    vcnt = CW'(7); hcnt = CW'(499); step();
    check(pls_out[2], 1'b0, "R6", 2);
    hcnt = CW'(500); step();
    check(pls_out[2], 1'b1, "R6", 2);

    tag = "random";
    for (int blk = 0; blk < 20; blk++) begin
      rand_config();
      for (int n = 0; n < 50; n++) begin
        pls_csel = 12'($urandom);
        hcnt = CW'($urandom); vcnt = CW'($urandom);
        step();
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired got running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule